// File: doc/BRIEF.md
# Zero-Crossing Edge Qualifier

This block turns the output of a mains zero-voltage detector, an asynchronous and often noisy single-bit signal from a 60 Hz line, into clean one-clock markers for each accepted crossing. The input first passes through a synchroniser. A qualification state machine then accepts a transition only after a second sample, taken a fixed debounce interval after the first, confirms the new level. If the level has gone back, the transition is treated as noise and the machine returns to waiting for that same transition. After reset the machine must observe the line high before it will accept any falling transition. This ties the first reference to a real one-to-zero crossing.

A confirmed rising transition is held back by a programmable compensation delay before it is reported. The delay corrects a detector whose switching point is not symmetric about zero volts. A mode input picks the reference scheme. In half-cycle mode both transitions produce a reference strobe. In full-cycle mode only the falling transition does, which gives one reference per line cycle. A separate cycle strobe marks every accepted falling transition in either mode. A lock flag reports that qualified transitions are arriving at line rate.

Top module: `zc_qualifier`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `ref_strobe`, `cycle_strobe` and `locked` are all 0.
- R2: After reset, a low detector level is not accepted as a falling transition until the synchronised input has been seen high at least once.
- R3: A falling transition is accepted only if the input is still low when resampled `DEB_CYC` cycles after first detection. With a 2-stage synchroniser, a low pulse of `DEB_CYC` cycles or fewer is rejected, and a low driven after clock edge N is reported in the cycle after edge N+3+`DEB_CYC`.
- R4: A rising transition is qualified in the same way: a high pulse of `DEB_CYC` cycles or fewer is rejected, and a confirmed high is accepted at edge N+3+`DEB_CYC`.
- R5: An accepted rising transition is reported `COMP_CYC` cycles after its confirmation, that is, after edge N+3+`DEB_CYC`+`COMP_CYC`.
- R6: With `full_mode`=0, `ref_strobe` pulses for accepted falling and rising transitions. With `full_mode`=1, `ref_strobe` pulses only for accepted falling transitions.
- R7: `cycle_strobe` pulses for every accepted falling transition in both modes, in the same cycle as `ref_strobe`, and never on a rising transition.
- R8: Every strobe is exactly one clock cycle wide.
- R9: `locked` rises on the first qualified transition, in the same cycle as that transition's `cycle_strobe`.
- R10: `locked` falls `HALF_CYC` + `HALF_CYC`/2 cycles after the last qualified transition (falling or rising confirmation) if no further transition has been qualified in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zvd_raw | input | 1 | Raw asynchronous detector level (1 = line above zero) |
| full_mode | input | 1 | 1: references on falling transitions only; 0: references on both transitions |
| ref_strobe | output | 1 | One-cycle reference marker |
| cycle_strobe | output | 1 | One-cycle marker for each accepted falling transition |
| locked | output | 1 | Qualified transitions are arriving within the timeout window |

## Verification
The hardest case to produce from the ports is a detector pulse whose length sits exactly on the debounce boundary. A pulse of `DEB_CYC` cycles must be rejected, while one of `DEB_CYC`+1 cycles must be accepted and its strobe must land on the computed edge. The stimulus drives both pulse lengths at clock-cycle resolution, counting the synchroniser stages. The lock timeout is probed a few cycles before and after the exact expiry edge, after a final falling transition that is left without a rising follow-up.

// File: rtl/zc_pkg.sv
package zc_pkg;

   typedef enum logic [2:0] {
      ZC_ARM       = 3'd0,
      ZC_WAIT_FALL = 3'd1,
      ZC_DEB_FALL  = 3'd2,
      ZC_WAIT_RISE = 3'd3,
      ZC_DEB_RISE  = 3'd4,
      ZC_COMP      = 3'd5
   } zc_state_e;

   function automatic int zc_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/zc_sync.sv
module zc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/zc_edge_fsm.sv
module zc_edge_fsm
   import zc_pkg::*;
#(
   parameter int DEB_CYC  = 250,
   parameter int COMP_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic full_mode,
   output logic fall_p,
   output logic ref_p,
   output logic confirm
);
   localparam int CNT_MAX = zc_max(DEB_CYC, COMP_CYC);
   localparam int CW      = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);
   localparam int COMP_L  = (COMP_CYC > 0) ? COMP_CYC - 1 : 0;
   localparam logic [CW-1:0] DEB_LAST  = CW'(DEB_CYC - 1);
   localparam logic [CW-1:0] COMP_LAST = CW'(COMP_L);

   zc_state_e       st, st_nxt, rise_done_st;
   logic [CW-1:0]   cnt, cnt_nxt;
   logic            fall_nxt, ref_nxt;

   generate
      if (COMP_CYC > 0) begin : g_comp
         assign rise_done_st = ZC_COMP;
      end else begin : g_nocomp
         assign rise_done_st = ZC_WAIT_FALL;
      end
   endgenerate

   always_comb begin
      st_nxt   = st;
      cnt_nxt  = cnt;
      fall_nxt = 1'b0;
      ref_nxt  = 1'b0;
      confirm  = 1'b0;
      case (st)
         ZC_ARM: begin
            if (lvl) st_nxt = ZC_WAIT_FALL;
         end
         ZC_WAIT_FALL: begin
            if (!lvl) begin
               st_nxt  = ZC_DEB_FALL;
               cnt_nxt = '0;
            end
         end
         ZC_DEB_FALL: begin
            cnt_nxt = cnt + 1'b1;
            if (cnt == DEB_LAST) begin
               if (!lvl) begin
                  confirm  = 1'b1;
                  fall_nxt = 1'b1;
                  ref_nxt  = 1'b1;
                  st_nxt   = ZC_WAIT_RISE;
               end else begin
                  st_nxt   = ZC_WAIT_FALL;
               end
            end
         end
         ZC_WAIT_RISE: begin
            if (lvl) begin
               st_nxt  = ZC_DEB_RISE;
               cnt_nxt = '0;
            end
         end
         ZC_DEB_RISE: begin
            cnt_nxt = cnt + 1'b1;
            if (cnt == DEB_LAST) begin
               if (lvl) begin
                  confirm = 1'b1;
                  cnt_nxt = '0;
                  st_nxt  = rise_done_st;
                  ref_nxt = (rise_done_st == ZC_WAIT_FALL) && !full_mode;
               end else begin
                  st_nxt  = ZC_WAIT_RISE;
               end
            end
         end
         ZC_COMP: begin
            cnt_nxt = cnt + 1'b1;
            if (cnt == COMP_LAST) begin
               ref_nxt = !full_mode;
               st_nxt  = ZC_WAIT_FALL;
            end
         end
         default: st_nxt = ZC_ARM;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ZC_ARM;
         cnt    <= '0;
         fall_p <= 1'b0;
         ref_p  <= 1'b0;
      end else begin
         st     <= st_nxt;
         cnt    <= cnt_nxt;
         fall_p <= fall_nxt;
         ref_p  <= ref_nxt;
      end
   end
endmodule

// File: rtl/zc_lock_timer.sv
module zc_lock_timer #(
   parameter int TIMEOUT = 12499
) (
   input  logic clk,
   input  logic rst_n,
   input  logic qual,
   output logic locked
);
   localparam int TW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT + 1);
   localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);

   logic [TW-1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age    <= '0;
         locked <= 1'b0;
      end else if (qual) begin
         age    <= '0;
         locked <= 1'b1;
      end else if (locked) begin
         if (age == T_LAST) locked <= 1'b0;
         else               age    <= age + 1'b1;
      end
   end
endmodule

// File: rtl/zc_qualifier.sv
module zc_qualifier #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYC     = 250,
   parameter int COMP_CYC    = 100,
   parameter int HALF_CYC    = 8333
) (
   input  logic clk,
   input  logic rst_n,
   input  logic zvd_raw,
   input  logic full_mode,
   output logic ref_strobe,
   output logic cycle_strobe,
   output logic locked
);
   localparam int LOCK_TIMEOUT = HALF_CYC + HALF_CYC / 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("zc_qualifier: SYNC_STAGES must be at least 2");
      end
      if (DEB_CYC < 1) begin : g_bad_deb
         $error("zc_qualifier: DEB_CYC must be at least 1");
      end
      if (COMP_CYC < 0) begin : g_bad_comp
         $error("zc_qualifier: COMP_CYC must not be negative");
      end
      if (LOCK_TIMEOUT <= DEB_CYC + COMP_CYC) begin : g_bad_half
         $error("zc_qualifier: HALF_CYC too short for debounce and compensation");
      end
   endgenerate

   logic lvl_s;
   logic confirm;

   zc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (zvd_raw),
      .sync_out (lvl_s)
   );

   zc_edge_fsm #(.DEB_CYC(DEB_CYC), .COMP_CYC(COMP_CYC)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl       (lvl_s),
      .full_mode (full_mode),
      .fall_p    (cycle_strobe),
      .ref_p     (ref_strobe),
      .confirm   (confirm)
   );

   zc_lock_timer #(.TIMEOUT(LOCK_TIMEOUT)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .qual   (confirm),
      .locked (locked)
   );
endmodule

// File: rtl/zc_qualifier_chk.sv
module zc_qualifier_chk (
   input logic clk,
   input logic rst_n,
   input logic zvd_raw,
   input logic full_mode,
   input logic ref_strobe,
   input logic cycle_strobe,
   input logic locked
);
   logic saw_high;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       saw_high <= 1'b0;
      else if (zvd_raw) saw_high <= 1'b1;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!ref_strobe && !cycle_strobe && !locked)
            else $error("R1: output active during reset");
      end
   end

   assert_arm_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_strobe |-> saw_high)
      else $error("R2: falling reference before input seen high");

   assert_full_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_strobe && !cycle_strobe) |-> !$past(full_mode))
      else $error("R6: rising reference in full-cycle mode");

   assert_cycle_is_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_strobe |-> ref_strobe)
      else $error("R7: cycle strobe without reference strobe");

   assert_ref_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ref_strobe |=> !ref_strobe)
      else $error("R8: reference strobe wider than one cycle");

   assert_cycle_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_strobe |=> !cycle_strobe)
      else $error("R8: cycle strobe wider than one cycle");

   assert_lock_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> cycle_strobe)
      else $error("R9: lock set without a falling reference");
endmodule

bind zc_qualifier zc_qualifier_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .zvd_raw      (zvd_raw),
   .full_mode    (full_mode),
   .ref_strobe   (ref_strobe),
   .cycle_strobe (cycle_strobe),
   .locked       (locked)
);

// File: tb/tb_zc_qualifier.sv
module tb_zc_qualifier;
   localparam int CLK_PERIOD = 10;
   localparam int DEB  = 8;
   localparam int COMP = 5;
   localparam int HALF = 100;
   localparam int LAT  = 3 + DEB;

   typedef struct {
      bit    is_fall;
      int    at;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic zvd_raw = 1'b0;
   logic full_mode = 1'b0;
   logic ref_strobe, cycle_strobe, locked;

   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   int   pulses = 0;
   bit   done = 1'b0;
   exp_t q[$];

   zc_qualifier #(
      .SYNC_STAGES (2),
      .DEB_CYC     (DEB),
      .COMP_CYC    (COMP),
      .HALF_CYC    (HALF)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .zvd_raw      (zvd_raw),
      .full_mode    (full_mode),
      .ref_strobe   (ref_strobe),
      .cycle_strobe (cycle_strobe),
      .locked       (locked)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // monitor: pops expected strobes and compares
   always @(negedge clk) begin
      if (rst_n && !done && (ref_strobe || cycle_strobe)) begin
         pulses++;
         if (q.size() == 0) begin
            check(1'b0, "R8 unexpected strobe", {30'd0, ref_strobe, cycle_strobe}, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(cyc == e.at, {e.tag, " strobe cycle"}, cyc, e.at);
            check(ref_strobe == 1'b1, {e.tag, " ref_strobe"}, ref_strobe, 1);
            check(cycle_strobe == e.is_fall, {e.tag, " cycle_strobe"}, cycle_strobe, e.is_fall);
         end
      end
   end

   task automatic push(input bit f, input int at, input string tag);
      exp_t e;
      e.is_fall = f;
      e.at = at;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // falling transition: reported after edge N+3+DEB (R3, R7)
   task automatic fall_edge(input string tag);
      @(negedge clk);
      zvd_raw = 1'b0;
      push(1'b1, cyc + LAT, tag);
      idle(40);
   endtask

   // rising transition: reported after N+3+DEB+COMP in half mode (R4, R5, R6)
   task automatic rise_edge(input bit expect_ref, input string tag);
      @(negedge clk);
      zvd_raw = 1'b1;
      if (expect_ref) push(1'b0, cyc + LAT + COMP, tag);
      idle(40);
   endtask

   task automatic glitch(input bit lvl, input int len);
      @(negedge clk);
      zvd_raw = lvl;
      idle(len);
      zvd_raw = ~lvl;
      idle(40);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired: actual 1 expected 0");
         finish_run();
      end
   end

   initial begin
      int n;
      idle(3);
      check(!ref_strobe && !cycle_strobe && !locked, "R1 reset outputs",
            {29'd0, ref_strobe, cycle_strobe, locked}, 0);
      rst_n = 1'b1;
      idle(1);
      check(!ref_strobe && !cycle_strobe && !locked, "R1 after release",
            {29'd0, ref_strobe, cycle_strobe, locked}, 0);

      // R2: low level after reset is not a falling transition
      idle(40);
      check(pulses == 0, "R2 no strobe before high seen", pulses, 0);
      check(locked == 1'b0, "R2 not locked before arming", locked, 0);

      zvd_raw = 1'b1;
      idle(40);
      fall_edge("R3 R7 R9 first fall");
      check(locked == 1'b1, "R9 locked after first fall", locked, 1);

      // half-cycle mode
      glitch(1'b1, 3);                 // R4 short high rejected
      rise_edge(1'b1, "R4 R5 R6 half rise");
      glitch(1'b0, 3);                 // R3 short low rejected
      glitch(1'b0, DEB);               // R3 boundary: DEB cycles rejected
      check(pulses == 2, "R3 R4 noise rejected", pulses, 2);

      // R3 boundary: DEB+1 cycles accepted, then rise
      @(negedge clk);
      zvd_raw = 1'b0;
      push(1'b1, cyc + LAT, "R3 boundary fall");
      idle(DEB + 1);
      zvd_raw = 1'b1;
      push(1'b0, cyc + LAT + COMP, "R4 R5 boundary rise");
      idle(40);

      // full-cycle mode: rising transitions give no reference (R6)
      full_mode = 1'b1;
      fall_edge("R6 R7 full fall 1");
      rise_edge(1'b0, "R6 full rise");
      fall_edge("R6 R7 full fall 2");
      n = pulses;

      // R10: lock expires HALF*3/2 cycles after the last confirmation
      idle(115);                       // 155 cycles after drive
      check(locked == 1'b1, "R10 locked before timeout", locked, 1);
      idle(15);                        // 170 cycles after drive
      check(locked == 1'b0, "R10 lock dropped after timeout", locked, 0);
      check(pulses == n, "R10 no strobe while idle", pulses, n);

      check(q.size() == 0, "R6 all expected strobes seen", q.size(), 0);
      finish_run();
   end
endmodule